// File: doc/BRIEF.md
# Threshold Interrupt Pin Controller

This block watches a stream of 16-bit proximity samples and turns them into an active-low interrupt pin and a status byte. Each sample is compared against a programmable upper and lower threshold. The pin follows one of three behaviours picked by a one-hot mode code: a comparator with hysteresis, a sticky wake-up latch, or a data-ready signal. The mode code can also switch the pin off.

Each 16-bit threshold is written as two bytes. A low-byte write only lands in a holding buffer. The following high-byte write commits the buffered byte and the new byte together, so a half-written threshold is never seen by the comparison. The data-ready indication is withdrawn when the host starts reading the data. When a new sample arrives during a read, or while the previous result is still unread, the pin gives a short pulse of fixed length instead of a held level.

Top module: `thr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset: `irq_n` is 1, `thr_hi` is 0xFFFF, `thr_lo` is 0x0000, and `status` is 0x70 while `osc_dead` is 0.
- R2: A low-byte write (`hi_lsb_we` or `lo_lsb_we`) leaves the matching `thr_hi`/`thr_lo` output unchanged.
- R3: A high-byte write sets the matching threshold to {`wr_data`, last staged low byte} in the cycle after the write edge.
- R4: The comparator state is set by a sample strictly greater than `thr_hi`, cleared by a sample strictly less than `thr_lo`, and held otherwise. With mode code 3'b010 (written by `mode_we` from `wr_data[2:0]`), `irq_n` is the inverse of that state.
- R5: With mode code 3'b001, a sample strictly above `thr_hi` sets a wake latch and drives `irq_n` low. The latch stays set through later samples and through rewrites of 3'b001, and is cleared by a mode write of any other code. No sample sets it outside that mode.
- R6: A sample that arrives with no unread result and no read in progress sets the data-ready flag and, in mode 3'b100, holds `irq_n` low until `rd_start` is registered. `rd_start` clears the flag.
- R7: A sample that arrives in the same cycle as `rd_start`, or within RD_WIN cycles after it, drives `irq_n` low (mode 3'b100) for exactly PULSE_CYC cycles. It still sets the data-ready flag.
- R8: A sample that arrives while the previous result is still unread produces the same PULSE_CYC-cycle pulse, and the data-ready flag stays set.
- R9: Status byte layout: bit 7 = `osc_dead`; bit 6 = 0 when the data-ready flag is set; bit 5 = 0 when the wake latch is set; bit 4 = 0 when the comparator state is set (above high) and 1 otherwise; bits 3:0 = 0.
- R10: Mode code 3'b000 and every code that is not one of 3'b001, 3'b010 or 3'b100 keep `irq_n` at 1, whatever the comparator and wake state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe for a new sample |
| smp_data | input | 16 | Proximity sample value |
| osc_dead | input | 1 | Oscillator stopped indication, reported in status bit 7 |
| wr_data | input | 8 | Byte carried by the write strobes |
| hi_lsb_we | input | 1 | Stage the low byte of the upper threshold |
| hi_msb_we | input | 1 | Commit the upper threshold |
| lo_lsb_we | input | 1 | Stage the low byte of the lower threshold |
| lo_msb_we | input | 1 | Commit the lower threshold |
| mode_we | input | 1 | Write the pin mode code from wr_data[2:0] |
| rd_start | input | 1 | Strobe marking the start of a read of the sample data |
| irq_n | output | 1 | Active-low interrupt pin |
| status | output | 8 | Status byte |
| thr_hi | output | 16 | Active upper threshold |
| thr_lo | output | 16 | Active lower threshold |

## Verification
The bench builds the block with PULSE_CYC = 3 and RD_WIN = 4 rather than the defaults of 4 and 8. With these values the full length and the trailing edge of a data-ready pulse can be checked cycle by cycle within a few clocks. A sample one cycle after a read start lands inside the short read window, and an idle gap of ten cycles is enough to make the window expire. The comparator walk places samples exactly on each threshold and one code either side, which reaches the strict-compare and hold cases.

// File: rtl/thr_irq_pkg.sv
// Package: shared mode codes and widths for the threshold interrupt pin controller.
// Assumes: mode codes are one-hot, and all codes not listed here count as "off".
package thr_irq_pkg;
    typedef enum logic [2:0] {
        PIN_OFF  = 3'b000,
        PIN_WAKE = 3'b001,
        PIN_CMP  = 3'b010,
        PIN_DRDY = 3'b100
    } pin_mode_e;

    localparam int MODE_W = 3;
    localparam int NUM_THR = 2;   // index 0 = upper, index 1 = lower
endpackage

// File: rtl/thr_stage.sv
// Module: thr_stage
// Two-byte threshold register. The low byte goes to a holding buffer and the
// high-byte write commits both halves at once.
// Assumes: W is even, and the write strobes are single-cycle pulses.
module thr_stage #(
    parameter int            W       = 16,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsb_we,
    input  logic             msb_we,
    input  logic [W/2-1:0]   wdata,
    output logic [W-1:0]     active
);
    localparam int HW = W / 2;

    logic [HW-1:0] stage_q;

    // Holding buffer for the low byte
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= RST_VAL[HW-1:0];
        else if (lsb_we) stage_q <= wdata;
    end

    // Active threshold, updated only by the high-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= RST_VAL;
        else if (msb_we) active <= {wdata, stage_q};
    end

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !msb_we |=> $stable(active)); // R2

    AST_COMMIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_we && !lsb_we) |=> active == {$past(wdata), $past(stage_q)}); // R3
endmodule

// File: rtl/thr_hyst_cmp.sv
// Module: thr_hyst_cmp
// Hysteresis comparator and wake-up latch. Both are updated on each valid
// sample.
// Assumes: when thr_hi < thr_lo and a sample meets both conditions, the
// upper condition wins.
module thr_hyst_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_data,
    input  logic [W-1:0] thr_hi,
    input  logic [W-1:0] thr_lo,
    input  logic         wake_en,
    input  logic         wake_clr,
    output logic         cmp_q,
    output logic         wake_q
);
    logic above_hi;
    logic below_lo;

    // Strict compares against the active thresholds
    always_comb begin
        above_hi = smp_data > thr_hi;
        below_lo = smp_data < thr_lo;
    end

    // Comparator state with a dead band between the thresholds
    always_ff @(posedge clk) begin
        if (!rst_n)                     cmp_q <= 1'b0;
        else if (smp_vld && above_hi)   cmp_q <= 1'b1;
        else if (smp_vld && below_lo)   cmp_q <= 1'b0;
    end

    // Wake latch: armed only in wake mode, cleared by leaving that mode
    always_ff @(posedge clk) begin
        if (!rst_n)                                wake_q <= 1'b0;
        else if (wake_clr)                         wake_q <= 1'b0;
        else if (smp_vld && wake_en && above_hi)   wake_q <= 1'b1;
    end

    AST_CMP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_data > thr_hi) |=> cmp_q); // R4

    AST_CMP_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld || (smp_data <= thr_hi && smp_data >= thr_lo)) |=> $stable(cmp_q)); // R4

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_q && !wake_clr) |=> wake_q); // R5

    AST_WAKE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_q && !wake_en) |=> !wake_q); // R5
endmodule

// File: rtl/drdy_seq.sv
// Module: drdy_seq
// Data-ready sequencer. It keeps the unread flag, the held-level request and
// the fixed-length pulse timer.
// Assumes: rd_start is a one-cycle strobe. A sample in the same cycle as
// rd_start counts as overlapping the read and keeps the flag set.
module drdy_seq #(
    parameter int PULSE_CYC = 4,
    parameter int RD_WIN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic rd_start,
    output logic flag_q,
    output logic drdy_act
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam int WW = $clog2(RD_WIN + 1);

    logic          hold_q;
    logic [PW-1:0] pcnt_q;
    logic [WW-1:0] wcnt_q;
    logic          overlap;

    // A read is in progress on its start cycle and for RD_WIN cycles after it
    always_comb overlap = rd_start || (wcnt_q != '0);

    // Read window counter
    always_ff @(posedge clk) begin
        if (!rst_n)              wcnt_q <= '0;
        else if (rd_start)       wcnt_q <= WW'(RD_WIN);
        else if (wcnt_q != '0)   wcnt_q <= wcnt_q - 1'b1;
    end

    // Unread flag: set by a sample, cleared by a read start
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (smp_vld)    flag_q <= 1'b1;
        else if (rd_start)   flag_q <= 1'b0;
    end

    // Held level for a clean sample, released by a read start
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= 1'b0;
        else if (smp_vld)    hold_q <= !(overlap || flag_q);
        else if (rd_start)   hold_q <= 1'b0;
    end

    // Pulse timer for samples that overlap a read or find unread data
    always_ff @(posedge clk) begin
        if (!rst_n)                         pcnt_q <= '0;
        else if (smp_vld && (overlap || flag_q)) pcnt_q <= PW'(PULSE_CYC);
        else if (smp_vld)                   pcnt_q <= '0;
        else if (pcnt_q != '0)              pcnt_q <= pcnt_q - 1'b1;
    end

    // Pin request from either source
    always_comb drdy_act = hold_q || (pcnt_q != '0);

    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt_q != '0 && !smp_vld) |=> pcnt_q == $past(pcnt_q) - 1'b1); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !smp_vld) |=> (!flag_q && !hold_q)); // R6

    AST_SAMPLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> flag_q); // R8
endmodule

// File: rtl/thr_irq_ctrl.sv
// Module: thr_irq_ctrl (top)
// Threshold interrupt pin controller. It holds the mode code and the two
// staged thresholds, the comparator/wake logic and the data-ready sequencer.
// It drives the active-low pin and builds the status byte.
// Assumes: one sample at most per cycle, and single-cycle write strobes that
// share wr_data.
module thr_irq_ctrl
    import thr_irq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PULSE_CYC = 4,
    parameter int RD_WIN    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              osc_dead,
    input  logic [DATA_W/2-1:0] wr_data,
    input  logic              hi_lsb_we,
    input  logic              hi_msb_we,
    input  logic              lo_lsb_we,
    input  logic              lo_msb_we,
    input  logic              mode_we,
    input  logic              rd_start,
    output logic              irq_n,
    output logic [7:0]        status,
    output logic [DATA_W-1:0] thr_hi,
    output logic [DATA_W-1:0] thr_lo
);
    localparam logic [DATA_W-1:0] HI_RST = '1;
    localparam logic [DATA_W-1:0] LO_RST = '0;

    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] thr_q [NUM_THR];
    logic [NUM_THR-1:0] lsb_we_v;
    logic [NUM_THR-1:0] msb_we_v;
    logic cmp_q, wake_q, flag_q, drdy_act;
    logic wake_clr;

    // Gather the per-threshold strobes into vectors
    always_comb begin
        lsb_we_v = {lo_lsb_we, hi_lsb_we};
        msb_we_v = {lo_msb_we, hi_msb_we};
    end

    // Mode code register, low bits of the write byte
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= PIN_OFF;
        else if (mode_we) mode_q <= wr_data[MODE_W-1:0];
    end

    // Leaving wake-up mode through a write clears the wake latch
    always_comb wake_clr = mode_we && (wr_data[MODE_W-1:0] != PIN_WAKE);

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        thr_stage #(
            .W       (DATA_W),
            .RST_VAL ((g == 0) ? HI_RST : LO_RST)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .lsb_we (lsb_we_v[g]),
            .msb_we (msb_we_v[g]),
            .wdata  (wr_data),
            .active (thr_q[g])
        );
    end

    // Publish the active thresholds
    always_comb begin
        thr_hi = thr_q[0];
        thr_lo = thr_q[1];
    end

    thr_hyst_cmp #(.W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .thr_hi   (thr_q[0]),
        .thr_lo   (thr_q[1]),
        .wake_en  (mode_q == PIN_WAKE),
        .wake_clr (wake_clr),
        .cmp_q    (cmp_q),
        .wake_q   (wake_q)
    );

    drdy_seq #(.PULSE_CYC(PULSE_CYC), .RD_WIN(RD_WIN)) u_drdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .rd_start (rd_start),
        .flag_q   (flag_q),
        .drdy_act (drdy_act)
    );

    // Pin selection: one source per legal code, idle high otherwise
    always_comb begin
        case (mode_q)
            PIN_WAKE: irq_n = !wake_q;
            PIN_CMP:  irq_n = !cmp_q;
            PIN_DRDY: irq_n = !drdy_act;
            default:  irq_n = 1'b1;
        endcase
    end

    // Status byte with active-low flags
    always_comb status = {osc_dead, !flag_q, !wake_q, !cmp_q, 4'b0000};

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PIN_WAKE && mode_q != PIN_CMP && mode_q != PIN_DRDY) |-> irq_n); // R10

    AST_WAKE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PIN_WAKE && !mode_we && !irq_n) |=> !irq_n); // R5
endmodule

// File: tb/thr_irq_ctrl_tb.sv
module thr_irq_ctrl_tb;
    localparam int PULSE = 3;
    localparam int WIN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic [15:0] smp_data = '0;
    logic osc_dead = 1'b0;
    logic [7:0] wr_data = '0;
    logic hi_lsb_we = 1'b0, hi_msb_we = 1'b0, lo_lsb_we = 1'b0, lo_msb_we = 1'b0;
    logic mode_we = 1'b0, rd_start = 1'b0;
    logic irq_n;
    logic [7:0] status;
    logic [15:0] thr_hi, thr_lo;

    int checks = 0;
    int fails = 0;

    // {sample, expected irq_n} in comparator mode with hi=0x8000, lo=0x4000 (R4)
    localparam logic [16:0] VEC [0:8] = '{
        {16'h5000, 1'b1}, {16'h8000, 1'b1}, {16'h8001, 1'b0},
        {16'h6000, 1'b0}, {16'h4000, 1'b0}, {16'h3FFF, 1'b1},
        {16'h7FFF, 1'b1}, {16'hFFFF, 1'b0}, {16'h0000, 1'b1}
    };

    always #10 clk = ~clk;

    thr_irq_ctrl #(.DATA_W(16), .PULSE_CYC(PULSE), .RD_WIN(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .osc_dead(osc_dead), .wr_data(wr_data), .hi_lsb_we(hi_lsb_we),
        .hi_msb_we(hi_msb_we), .lo_lsb_we(lo_lsb_we), .lo_msb_we(lo_msb_we),
        .mode_we(mode_we), .rd_start(rd_start), .irq_n(irq_n), .status(status),
        .thr_hi(thr_hi), .thr_lo(thr_lo)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sample(input logic [15:0] v);
        smp_vld = 1'b1; smp_data = v;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic read_start();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    // sel: 0 hi lsb, 1 hi msb, 2 lo lsb, 3 lo msb, 4 mode
    task automatic wr(input int sel, input logic [7:0] d);
        wr_data = d;
        hi_lsb_we = (sel == 0); hi_msb_we = (sel == 1);
        lo_lsb_we = (sel == 2); lo_msb_we = (sel == 3);
        mode_we = (sel == 4);
        @(negedge clk);
        {hi_lsb_we, hi_msb_we, lo_lsb_we, lo_msb_we, mode_we} = '0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_n", 16'(irq_n), 16'h1);
        check("R1 thr_hi", thr_hi, 16'hFFFF);
        check("R1 thr_lo", thr_lo, 16'h0000);
        check("R1 status", 16'(status), 16'h70);

        // R2 staging, R3 commit
        wr(0, 8'h00);
        check("R2 hi lsb staged only", thr_hi, 16'hFFFF);
        wr(1, 8'h80);
        check("R3 hi commit", thr_hi, 16'h8000);
        wr(2, 8'h00);
        check("R2 lo lsb staged only", thr_lo, 16'h0000);
        wr(3, 8'h40);
        check("R3 lo commit", thr_lo, 16'h4000);
        wr(2, 8'h11);
        wr(2, 8'h22);
        wr(3, 8'h40);
        check("R3 last staged byte used", thr_lo, 16'h4022);
        wr(2, 8'h00);
        wr(3, 8'h40);

        // R4 comparator walk
        wr(4, 8'h02);
        for (int i = 0; i < 9; i++) begin
            sample(VEC[i][16:1]);
            check($sformatf("R4 vec %0d", i), 16'(irq_n), 16'(VEC[i][0]));
        end

        // R5 wake latch
        wr(4, 8'h01);
        check("R5 wake idle", 16'(irq_n), 16'h1);
        sample(16'h9000);
        check("R5 wake set", 16'(irq_n), 16'h0);
        check("R9 wake bit5 low", 16'(status[5]), 16'h0);
        sample(16'h0000);
        check("R5 wake holds below low", 16'(irq_n), 16'h0);
        wr(4, 8'h01);
        check("R5 same-mode rewrite keeps", 16'(irq_n), 16'h0);
        wr(4, 8'h02);
        check("R5 leave clears", 16'(status[5]), 16'h1);
        check("R4 cmp pin after wake", 16'(irq_n), 16'h1);
        sample(16'h9000);
        check("R5 no arm outside mode", 16'(status[5]), 16'h1);
        check("R4 cmp set", 16'(irq_n), 16'h0);

        // R9 status layout: flag set, wake clear, above high
        check("R9 status", 16'(status), 16'h20);
        osc_dead = 1'b1;
        #1 check("R9 osc bit", 16'(status), 16'hA0);
        osc_dead = 1'b0;

        // R10 reserved and off codes
        wr(4, 8'h03);
        check("R10 code 011", 16'(irq_n), 16'h1);
        wr(4, 8'h07);
        check("R10 code 111", 16'(irq_n), 16'h1);
        wr(4, 8'h00);
        check("R10 code 000", 16'(irq_n), 16'h1);

        // R6 data-ready held level
        read_start();
        repeat (10) @(negedge clk);
        wr(4, 8'h04);
        check("R6 idle", 16'(irq_n), 16'h1);
        sample(16'h1234);
        check("R6 asserted", 16'(irq_n), 16'h0);
        check("R6 flag", 16'(status[6]), 16'h0);
        repeat (10) @(negedge clk);
        check("R6 held", 16'(irq_n), 16'h0);
        read_start();
        check("R6 released", 16'(irq_n), 16'h1);
        check("R6 flag cleared", 16'(status[6]), 16'h1);
        repeat (10) @(negedge clk);

        // R7 sample overlapping a read gives a pulse
        read_start();
        sample(16'h2222);
        check("R7 pulse start", 16'(irq_n), 16'h0);
        check("R7 flag set", 16'(status[6]), 16'h0);
        repeat (2) @(negedge clk);
        check("R7 pulse last", 16'(irq_n), 16'h0);
        @(negedge clk);
        check("R7 pulse end", 16'(irq_n), 16'h1);
        read_start();
        repeat (10) @(negedge clk);

        // R8 unread result repeats as a pulse
        sample(16'h3333);
        check("R8 first held", 16'(irq_n), 16'h0);
        sample(16'h3334);
        check("R8 pulse start", 16'(irq_n), 16'h0);
        repeat (2) @(negedge clk);
        check("R8 pulse last", 16'(irq_n), 16'h0);
        @(negedge clk);
        check("R8 pulse end", 16'(irq_n), 16'h1);
        check("R8 flag still set", 16'(status[6]), 16'h0);

        // R1 reset again mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rerst thr_hi", thr_hi, 16'hFFFF);
        check("R1 rerst thr_lo", thr_lo, 16'h0000);
        check("R1 rerst status", 16'(status), 16'h70);
        check("R1 rerst irq_n", 16'(irq_n), 16'h1);

        summary();
        $finish;
    end
endmodule